// File: doc/BRIEF.md
# Guarded Self-Test Enable Register

This block holds one control bit that decides whether the hardware self-test runs once reset is released. A value of 1 runs the test and a value of 0 skips it. The bit is kept in three redundant flip-flops. A majority vote of those three produces the value that is read back and the value driven onto the enable output. On every pulse of the slow reference tick, the voted result is written back into all three copies, so a single upset is repaired.

Software cannot change the bit with a plain store. It must first write an unlock key to a command location. The very next bus access must then be the data write. A write that is accepted does not take effect at once: the new value becomes visible after a few reference ticks, and the block stays busy for a longer window. Any write that arrives during that window is thrown away and flagged. Only the power-on and brown-out reset inputs restore the default.

The bus is an 8-bit port with a small address space:
- address 0 is the control register;
- address 1 is the command location;
- address 2 is a read-only status byte.

Top module: `bist_guard_reg`

## Requirements
- R1: While `por_n` or `bod_n` is low, and after it returns high, reading address 0 gives 0x01, `bist_en` is 1 and reading address 2 gives 0x00.
- R2: Reading address 0 returns the voted bit in bit 0 and zeros in bits 7..1. `bist_en` always equals that bit.
- R3: A write of 0xA5 to address 1 arms the guard. If the next access is a write to address 0, it is accepted and its data bit 0 becomes the new value. A write to address 0 with the guard not armed is ignored. A write of any other value to address 1 does not arm the guard.
- R4: While the guard is armed, any access other than a write to address 0 disarms it and sets the sticky protection-error flag (status bit 0). A following write to address 0 is ignored.
- R5: An accepted value appears on the read data and on `bist_en` at the third `ref_tick` counted after the write cycle. Before that, the old value is still returned.
- R6: The busy flag (status bit 1) is 1 from the cycle after an accepted write until the sixth `ref_tick` counted after it.
- R7: An unlocked write to address 0 that arrives while busy is high is discarded. It sets the sticky dropped-write flag (status bit 2) and changes neither the stored value nor the busy window.
- R8: Inverting any single copy leaves the read value and `bist_en` unchanged. Inverting two copies that hold the same value changes both.
- R9: On every `ref_tick`, all three copies are reloaded from the voted value (or from the committing value), so two single upsets separated by a tick never change the output.
- R10: The stored bit and the sticky flags are cleared only by `por_n` or `bod_n`. No bus access clears the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bod_n | input | 1 | Brown-out detect reset, active low, asynchronous |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| acc_en | input | 1 | Bus access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | 0 control, 1 command, 2 status |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the addressed location |
| seu_flip | input | 3 | Fault-injection hook: inverts the selected copies on this cycle |
| bist_en | output | 1 | Voted self-test enable |

## Verification
A table of key and data pairs is applied through the guard. Each pair is followed by a full commit window and a readback. The pairs include:
- correct keys, which distinguish acceptance;
- near-miss and zero keys, which show that arming needs the exact key;
- data bytes with upper bits set, which show that only bit 0 is stored.

Directed sequences then cover these cases:
- a read two ticks after a write against a read after the third tick, which separates visible timing from busy timing;
- a second write inside the busy window, which must be dropped;
- a read placed between key and data, which must abort the sequence;
- single and double copy flips around a scrub tick;
- each of the two reset inputs.

// File: rtl/bgr_pkg.sv
package bgr_pkg;
   localparam int STAT_ERR_BIT  = 0;
   localparam int STAT_BUSY_BIT = 1;
   localparam int STAT_DROP_BIT = 2;

   typedef struct packed {
      logic dropped;
      logic busy;
      logic prot_err;
   } bgr_status_t;
endpackage

// File: rtl/bgr_voted_bit.sv
module bgr_voted_bit #(
   parameter int   COPIES    = 3,
   parameter logic RESET_BIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              apply,
   input  logic              apply_val,
   input  logic [COPIES-1:0] flip,
   output logic              vote
);
   localparam int MAJ = COPIES / 2 + 1;

   logic [COPIES-1:0] copy_q;
   logic              base;

   if ((COPIES % 2) == 0 || COPIES < 3) begin : g_bad_copies
      $error("bgr_voted_bit: COPIES must be odd and at least 3");
   end

   if (COPIES == 3) begin : g_vote3
      assign vote = (copy_q[0] & copy_q[1]) | (copy_q[1] & copy_q[2]) |
                    (copy_q[0] & copy_q[2]);
   end else begin : g_voteN
      always_comb vote = ($countones(copy_q) >= MAJ);
   end

   assign base = apply ? apply_val : vote;

   for (genvar i = 0; i < COPIES; i++) begin : g_copy
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    copy_q[i] <= RESET_BIT;
         else if (tick) copy_q[i] <= base ^ flip[i];
         else           copy_q[i] <= copy_q[i] ^ flip[i];
      end
   end

   // R8
   quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && flip == '0) |=> $stable(vote));
   // R9
   scrub_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && flip == '0) |=> (copy_q == '0 || copy_q == '1));
endmodule

// File: rtl/bgr_unlock.sv
module bgr_unlock #(
   parameter int         ADDR_W    = 2,
   parameter int         DATA_W    = 8,
   parameter logic [7:0] KEY       = 8'hA5,
   parameter int         CTRL_ADDR = 0,
   parameter int         CMD_ADDR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              wr_ok,
   output logic              prot_err
);
   logic armed_q, err_q, ctrl_wr, key_wr, abort;

   if (DATA_W < 8) begin : g_bad_width
      $error("bgr_unlock: DATA_W must hold the key");
   end

   assign ctrl_wr = acc_en && acc_wr && (acc_addr == ADDR_W'(CTRL_ADDR));
   assign key_wr  = acc_en && acc_wr && (acc_addr == ADDR_W'(CMD_ADDR)) &&
                    (acc_wdata[7:0] == KEY);
   assign wr_ok   = armed_q && ctrl_wr;
   assign abort   = armed_q && acc_en && !ctrl_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (armed_q) armed_q <= !acc_en;
         else         armed_q <= key_wr;
         if (abort)   err_q   <= 1'b1;
      end
   end

   assign prot_err = err_q;

   // R4
   abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && acc_en && !(acc_wr && acc_addr == ADDR_W'(CTRL_ADDR)))
      |=> (prot_err && !armed_q));
   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prot_err |=> prot_err);
endmodule

// File: rtl/bgr_commit.sv
module bgr_commit #(
   parameter int VIS_TICKS  = 3,
   parameter int FULL_TICKS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic wval,
   input  logic tick,
   output logic busy,
   output logic apply,
   output logic apply_val
);
   localparam int CNT_W = $clog2(FULL_TICKS + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q, val_q, done;

   if (VIS_TICKS < 1 || VIS_TICKS > FULL_TICKS) begin : g_bad_ticks
      $error("bgr_commit: need 1 <= VIS_TICKS <= FULL_TICKS");
   end

   assign apply     = busy_q && tick && (cnt_q == CNT_W'(VIS_TICKS - 1));
   assign done      = busy_q && tick && (cnt_q == CNT_W'(FULL_TICKS - 1));
   assign apply_val = val_q;
   assign busy      = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         val_q  <= 1'b0;
      end else if (accept && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         val_q  <= wval;
      end else if (done) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q && tick) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // R6
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> busy);
   // R6
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(accept));
   // R6
   idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cnt_q == '0));
endmodule

// File: rtl/bist_guard_reg.sv
module bist_guard_reg #(
   parameter int         DATA_W     = 8,
   parameter int         ADDR_W     = 2,
   parameter int         COPIES     = 3,
   parameter logic [7:0] KEY        = 8'hA5,
   parameter int         VIS_TICKS  = 3,
   parameter int         FULL_TICKS = 6,
   parameter logic       RESET_BIT  = 1'b1,
   parameter int         CTRL_ADDR  = 0,
   parameter int         CMD_ADDR   = 1,
   parameter int         STAT_ADDR  = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              bod_n,
   input  logic              ref_tick,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic [COPIES-1:0] seu_flip,
   output logic              bist_en
);
   import bgr_pkg::*;

   logic        rst_n, wr_ok, accept, busy, apply, apply_val, vote, drop_q;
   bgr_status_t stat;

   if (CTRL_ADDR == CMD_ADDR || CTRL_ADDR == STAT_ADDR || CMD_ADDR == STAT_ADDR)
   begin : g_bad_map
      $error("bist_guard_reg: addresses must differ");
   end

   assign rst_n = por_n & bod_n;

   bgr_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY),
                .CTRL_ADDR(CTRL_ADDR), .CMD_ADDR(CMD_ADDR)) u_unlock (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .wr_ok(wr_ok), .prot_err(stat.prot_err));

   assign accept = wr_ok && !busy;

   bgr_commit #(.VIS_TICKS(VIS_TICKS), .FULL_TICKS(FULL_TICKS)) u_commit (
      .clk(clk), .rst_n(rst_n), .accept(accept), .wval(acc_wdata[0]),
      .tick(ref_tick), .busy(busy), .apply(apply), .apply_val(apply_val));

   bgr_voted_bit #(.COPIES(COPIES), .RESET_BIT(RESET_BIT)) u_bit (
      .clk(clk), .rst_n(rst_n), .tick(ref_tick), .apply(apply),
      .apply_val(apply_val), .flip(seu_flip), .vote(vote));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             drop_q <= 1'b0;
      else if (wr_ok && busy) drop_q <= 1'b1;
   end

   assign stat.busy    = busy;
   assign stat.dropped = drop_q;
   assign bist_en      = vote;

   always_comb begin
      acc_rdata = '0;
      if (acc_addr == ADDR_W'(CTRL_ADDR))      acc_rdata[0] = vote;
      else if (acc_addr == ADDR_W'(STAT_ADDR)) begin
         acc_rdata[STAT_ERR_BIT]  = stat.prot_err;
         acc_rdata[STAT_BUSY_BIT] = stat.busy;
         acc_rdata[STAT_DROP_BIT] = stat.dropped;
      end
   end

   // R7
   drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && busy) |=> stat.dropped);
   // R5
   commit_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && seu_flip == '0) |=> (bist_en == $past(apply_val)));
   // R10
   drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat.dropped |=> stat.dropped);
endmodule

// File: tb/sim_bist_guard_reg.sv
module sim_bist_guard_reg;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, bod_n = 1'b1, ref_tick = 1'b0;
   logic       acc_en = 1'b0, acc_wr = 1'b0;
   logic [1:0] acc_addr = 2'd0;
   logic [7:0] acc_wdata = 8'h00;
   logic [7:0] acc_rdata;
   logic [2:0] seu_flip = 3'b000;
   logic       bist_en;
   int         checks = 0, errors = 0;
   logic [7:0] rv;

   always #10 clk = ~clk;

   bist_guard_reg u0 (.clk(clk), .por_n(por_n), .bod_n(bod_n),
      .ref_tick(ref_tick), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .seu_flip(seu_flip), .bist_en(bist_en));

   // {key, data, expected control readback}
   localparam logic [23:0] VEC [7] = '{
      {8'hA5, 8'h00, 8'h00}, {8'hA5, 8'hFF, 8'h01}, {8'h5A, 8'h00, 8'h01},
      {8'hA5, 8'hFE, 8'h00}, {8'h00, 8'h01, 8'h00}, {8'hA5, 8'h03, 8'h01},
      {8'hA4, 8'h00, 8'h01}};

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
      #2 d = acc_rdata;
      @(negedge clk);
      acc_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
      end
   endtask

   task automatic flip(input logic [2:0] m);
      @(negedge clk); seu_flip = m;
      @(negedge clk); seu_flip = 3'b000;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 20000);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      // R1 reset state
      rd(2'd0, rv); chk("R1 ctrl", rv, 8'h01);
      chk("R1 bist_en", {7'd0, bist_en}, 8'h01);
      rd(2'd2, rv); chk("R1 status", rv, 8'h00);

      // R2 R3 table walk
      foreach (VEC[i]) begin
         wr(2'd1, VEC[i][23:16]);
         wr(2'd0, VEC[i][15:8]);
         ticks(6);
         rd(2'd0, rv); chk("R3 R2 table", rv, VEC[i][7:0]);
         chk("R2 bist_en", {7'd0, bist_en}, VEC[i][7:0]);
      end
      rd(2'd2, rv); chk("R3 no error flags", rv, 8'h00);

      // R5 R6 R7 timing; value now 01
      wr(2'd1, 8'hA5); wr(2'd0, 8'h00);
      rd(2'd2, rv); chk("R6 busy set", rv, 8'h02);
      ticks(2);
      rd(2'd0, rv); chk("R5 old before third tick", rv, 8'h01);
      ticks(1);
      rd(2'd0, rv); chk("R5 new at third tick", rv, 8'h00);
      chk("R5 bist_en", {7'd0, bist_en}, 8'h00);
      wr(2'd1, 8'hA5); wr(2'd0, 8'h01);
      rd(2'd2, rv); chk("R7 dropped flag", rv, 8'h06);
      ticks(2);
      rd(2'd2, rv); chk("R6 busy before sixth", rv, 8'h06);
      ticks(1);
      rd(2'd2, rv); chk("R6 busy cleared", rv, 8'h04);
      ticks(4);
      rd(2'd0, rv); chk("R7 dropped value absent", rv, 8'h00);

      // R4 abort
      wr(2'd1, 8'hA5);
      rd(2'd2, rv);
      rd(2'd2, rv); chk("R4 error flag", rv, 8'h05);
      wr(2'd0, 8'h01); ticks(6);
      rd(2'd0, rv); chk("R4 write ignored", rv, 8'h00);

      // R8 R9 majority and scrub; value 0
      flip(3'b001);
      chk("R8 single flip", {7'd0, bist_en}, 8'h00);
      rd(2'd0, rv); chk("R8 single flip read", rv, 8'h00);
      ticks(1);
      flip(3'b010);
      chk("R9 scrubbed before second flip", {7'd0, bist_en}, 8'h00);
      flip(3'b100);
      chk("R8 double flip changes", {7'd0, bist_en}, 8'h01);
      ticks(1);
      rd(2'd0, rv); chk("R9 scrub keeps vote", rv, 8'h01);

      // R10 brown-out and power-on resets
      wr(2'd1, 8'hA5); wr(2'd0, 8'h00); ticks(6);
      rd(2'd0, rv); chk("R10 value before bod", rv, 8'h00);
      @(negedge clk); bod_n = 1'b0;
      @(negedge clk); bod_n = 1'b1;
      rd(2'd0, rv); chk("R10 R1 bod ctrl", rv, 8'h01);
      rd(2'd2, rv); chk("R10 R1 bod status", rv, 8'h00);
      wr(2'd1, 8'hA5); rd(2'd0, rv);
      rd(2'd2, rv); chk("R10 flag set again", rv, 8'h01);
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      rd(2'd2, rv); chk("R10 R1 por status", rv, 8'h00);
      chk("R1 por bist_en", {7'd0, bist_en}, 8'h01);

      finish_run();
   end
endmodule